// File: doc/BRIEF.md
# Core Module System Control Register Bank

This block is the control and status register file of a processor core module. A host reaches it over a simple word-addressed bus: each cycle it may present one request, a read or a write of a 32-bit word at a 6-bit word index. Read data comes back from a register one cycle later, together with a response valid flag. The bank holds fixed identity and status words, two clock-synthesizer settings that can only be changed after an unlock key has been written, a control word, SDRAM and init configuration words, two flag words with separate set and clear addresses, and a free-running reference counter.

The control word drives three board-level signals: an LED level, a remap level that moves boot flash away from address zero, and a single-cycle system reset request. A reset request also wipes the ordinary flag word, but the non-volatile flag word keeps its contents until power-on reset (rst_ni). The reference counter advances on a tick-enable input, so the integrator can feed it from any reference rate, such as a 24 MHz strobe.

Top module: `core_ctrl_regs`

## Requirements
- R1: After reset, reads return: index 0 = 0x411A3001, index 4 = 0x00100000, index 2 = 0x01000048, index 7 = 0x0007FEFF, index 8 = 0x00011122, index 9 = 0x00000112. Indices 3, 5, 10, 12 and 14 read zero.
- R2: A read request (valid high, write low) sampled at a clock edge yields rsp_valid_o high and the read data on rsp_rdata_o after that edge. rsp_valid_o is low in every other cycle.
- R3: A write to index 5 stores the low 16 bits of the data. While the stored value is 0xA05F, index 5 reads 0x0001A05F. Otherwise it reads the stored value, zero-extended.
- R4: Writes to index 2 and index 7 are ignored unless the value stored at index 5 is 0xA05F at the time of the write.
- R5: A write to index 3 keeps only data bits 0 and 2. led_o follows bit 0 and remap_o follows bit 2 from the cycle after the write. A read of index 3 returns those two bits in their positions.
- R6: A write to index 3 with data bit 3 set drives sys_reset_req_o high for exactly the one cycle after the write. Bit 3 always reads back as zero.
- R7: A write to index 12 ORs the data into the flag word. A write to index 13 clears every flag bit that is 1 in the data. Index 12 reads the flag word and index 13 reads zero.
- R8: Indices 14 and 15 set and clear the non-volatile flag word in the same way, and index 14 reads it. A reset-request write (R6) zeroes the flag word of R7 but leaves the non-volatile word unchanged.
- R9: Index 10 reads a 32-bit counter that is zero after reset, advances by one at each clock edge where tick_i is high, and wraps modulo 2^32. A read returns the count reached before the read's own edge.
- R10: Indices 8 and 9 take any written value. Writes to every other index outside 2, 3, 5, 7, 8, 9 and 12 to 15 change no state, and reads of indices not listed in R1 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Reference counter advance enable |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (6) | Word index |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| led_o | output | 1 | LED level from control bit 0 |
| remap_o | output | 1 | Boot-flash remap level from control bit 2 |
| sys_reset_req_o | output | 1 | One-cycle system reset request |

## Verification
Every result of this block appears one edge after the request that causes it. Register contents, led_o and remap_o change at the write's edge. The reset pulse is high for the single cycle after the write edge. Read data and rsp_valid_o are registered at the read's edge. The bench drives each request at a falling edge and samples all outputs at the next falling edge, so every sample lands in the cycle where a result is due. For the pulse it takes one more sample a cycle later to confirm that it has dropped. The counter is ticked only in bursts of known length with no read in between, so the expected count is the number of high-tick edges.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int DW = 32;

  localparam int OFF_ID     = 0;
  localparam int OFF_OSC    = 2;
  localparam int OFF_CTRL   = 3;
  localparam int OFF_STAT   = 4;
  localparam int OFF_LOCK   = 5;
  localparam int OFF_AUX    = 7;
  localparam int OFF_SDRAM  = 8;
  localparam int OFF_INIT   = 9;
  localparam int OFF_REFCNT = 10;
  localparam int OFF_FSET   = 12;
  localparam int OFF_FCLR   = 13;
  localparam int OFF_NVSET  = 14;
  localparam int OFF_NVCLR  = 15;

  localparam logic [DW-1:0] ID_VAL    = 32'h411A_3001;
  localparam logic [DW-1:0] STAT_VAL  = 32'h0010_0000;
  localparam logic [DW-1:0] OSC_RST   = 32'h0100_0048;
  localparam logic [DW-1:0] AUX_RST   = 32'h0007_FEFF;
  localparam logic [DW-1:0] SDRAM_RST = 32'h0001_1122;
  localparam logic [DW-1:0] INIT_RST  = 32'h0000_0112;
  localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;

  localparam int CTRL_LED_BIT   = 0;
  localparam int CTRL_REMAP_BIT = 2;
  localparam int CTRL_RST_BIT   = 3;

  typedef struct packed {
    logic osc;
    logic ctrl;
    logic lock;
    logic aux;
    logic sdram;
    logic init;
    logic fset;
    logic fclr;
    logic nvset;
    logic nvclr;
  } wr_strobe_t;
endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        wr_o
);
  logic we;
  assign we = valid_i & write_i;

  always_comb begin
    wr_o       = '0;
    wr_o.osc   = we && (addr_i == ADDR_W'(OFF_OSC));
    wr_o.ctrl  = we && (addr_i == ADDR_W'(OFF_CTRL));
    wr_o.lock  = we && (addr_i == ADDR_W'(OFF_LOCK));
    wr_o.aux   = we && (addr_i == ADDR_W'(OFF_AUX));
    wr_o.sdram = we && (addr_i == ADDR_W'(OFF_SDRAM));
    wr_o.init  = we && (addr_i == ADDR_W'(OFF_INIT));
    wr_o.fset  = we && (addr_i == ADDR_W'(OFF_FSET));
    wr_o.fclr  = we && (addr_i == ADDR_W'(OFF_FCLR));
    wr_o.nvset = we && (addr_i == ADDR_W'(OFF_NVSET));
    wr_o.nvclr = we && (addr_i == ADDR_W'(OFF_NVCLR));
  end
endmodule

// File: rtl/ccr_lock.sv
module ccr_lock
  import ccr_pkg::*;
#(
  parameter int             KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] wdata_i,
  output logic             unlocked_o,
  output logic [DW-1:0]    rd_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_q <= '0;
    else if (wr_i) key_q <= wdata_i;
  end

  assign unlocked_o = (key_q == KEY);
  // unlocked state shows as the bit just above the key field
  assign rd_o = {{(DW-KEY_W-1){1'b0}}, unlocked_o, key_q};
endmodule

// File: rtl/ccr_setclr.sv
module ccr_setclr #(
  parameter int W        = 32,
  parameter bit SOFT_CLR = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic         soft_clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic wipe;
  assign wipe = SOFT_CLR & soft_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wipe)  q_o <= '0;
    else if (set_i) q_o <= q_o | data_i;
    else if (clr_i) q_o <= q_o & ~data_i;
  end
endmodule

// File: rtl/ccr_refcnt.sv
module ccr_refcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/core_ctrl_regs.sv
module core_ctrl_regs
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int KEY_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rsp_rdata_o,
  output logic              led_o,
  output logic              remap_o,
  output logic              sys_reset_req_o
);
  localparam logic [KEY_W-1:0] KEY = KEY_W'(UNLOCK_KEY);
  localparam int NFLAG = 2;

  wr_strobe_t wr;
  logic       unlocked;
  logic       soft_rst;
  logic [DW-1:0] lock_rd;
  logic [DW-1:0] osc_q, aux_q, sdram_q, init_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0] flag_q [NFLAG];
  logic [DW-1:0] rd_mux;

  ccr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .valid_i (req_valid_i),
    .write_i (req_write_i),
    .addr_i  (req_addr_i),
    .wr_o    (wr)
  );

  ccr_lock #(.KEY_W(KEY_W), .KEY(KEY)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr.lock),
    .wdata_i    (req_wdata_i[KEY_W-1:0]),
    .unlocked_o (unlocked),
    .rd_o       (lock_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q   <= OSC_RST;
      aux_q   <= AUX_RST;
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
    end else begin
      if (wr.osc && unlocked) osc_q <= req_wdata_i;
      if (wr.aux && unlocked) aux_q <= req_wdata_i;
      if (wr.sdram)           sdram_q <= req_wdata_i;
      if (wr.init)            init_q <= req_wdata_i;
    end
  end

  assign soft_rst = wr.ctrl & req_wdata_i[CTRL_RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_o           <= 1'b0;
      remap_o         <= 1'b0;
      sys_reset_req_o <= 1'b0;
    end else begin
      sys_reset_req_o <= soft_rst;
      if (wr.ctrl) begin
        led_o   <= req_wdata_i[CTRL_LED_BIT];
        remap_o <= req_wdata_i[CTRL_REMAP_BIT];
      end
    end
  end

  // index 0: volatile flags (wiped by reset request), index 1: non-volatile
  for (genvar g = 0; g < NFLAG; g++) begin : g_flags
    ccr_setclr #(.W(DW), .SOFT_CLR(g == 0)) u_setclr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      ((g == 0) ? wr.fset : wr.nvset),
      .clr_i      ((g == 0) ? wr.fclr : wr.nvclr),
      .soft_clr_i (soft_rst),
      .data_i     (req_wdata_i),
      .q_o        (flag_q[g])
    );
  end

  ccr_refcnt #(.W(CNT_W)) u_refcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (cnt_q)
  );

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      ADDR_W'(OFF_ID):     rd_mux = ID_VAL;
      ADDR_W'(OFF_OSC):    rd_mux = osc_q;
      ADDR_W'(OFF_CTRL): begin
        rd_mux[CTRL_LED_BIT]   = led_o;
        rd_mux[CTRL_REMAP_BIT] = remap_o;
      end
      ADDR_W'(OFF_STAT):   rd_mux = STAT_VAL;
      ADDR_W'(OFF_LOCK):   rd_mux = lock_rd;
      ADDR_W'(OFF_AUX):    rd_mux = aux_q;
      ADDR_W'(OFF_SDRAM):  rd_mux = sdram_q;
      ADDR_W'(OFF_INIT):   rd_mux = init_q;
      ADDR_W'(OFF_REFCNT): rd_mux = DW'(cnt_q);
      ADDR_W'(OFF_FSET):   rd_mux = flag_q[0];
      ADDR_W'(OFF_NVSET):  rd_mux = flag_q[1];
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i & ~req_write_i;
      if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/ccr_regs_chk.sv
module ccr_regs_chk
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              wd_led_i,
  input logic              wd_remap_i,
  input logic              wd_rst_i,
  input logic              rsp_valid_o,
  input logic              led_o,
  input logic              remap_o,
  input logic              sys_reset_req_o,
  input logic [DW-1:0]     osc_q,
  input logic              unlocked,
  input logic [CNT_W-1:0]  cnt_q
);
  logic rd_req, ctrl_wr, osc_wr, rst_wr;
  assign rd_req  = req_valid_i && !req_write_i;
  assign ctrl_wr = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFF_CTRL));
  assign osc_wr  = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFF_OSC));
  assign rst_wr  = ctrl_wr && wd_rst_i;

  AST_RSP_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o); // R2
  AST_RSP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o); // R2
  AST_OSC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_wr && !unlocked) |=> $stable(osc_q)); // R4
  AST_LED_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (led_o == $past(wd_led_i))); // R5
  AST_REMAP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> (remap_o == $past(wd_remap_i))); // R5
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_wr |=> sys_reset_req_o); // R6
  AST_RST_ONLY_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_wr |=> !sys_reset_req_o); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9
endmodule

bind core_ctrl_regs ccr_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .tick_i          (tick_i),
  .req_valid_i     (req_valid_i),
  .req_write_i     (req_write_i),
  .req_addr_i      (req_addr_i),
  .wd_led_i        (req_wdata_i[0]),
  .wd_remap_i      (req_wdata_i[2]),
  .wd_rst_i        (req_wdata_i[3]),
  .rsp_valid_o     (rsp_valid_o),
  .led_o           (led_o),
  .remap_o         (remap_o),
  .sys_reset_req_o (sys_reset_req_o),
  .osc_q           (osc_q),
  .unlocked        (unlocked),
  .cnt_q           (cnt_q)
);

// File: tb/core_ctrl_regs_bench.sv
`timescale 1ns/1ps
module core_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        led, remap, rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_cnt;
  logic [15:0] m_lock;
  logic        m_led, m_remap;

  always #2 clk = ~clk;

  core_ctrl_regs u_core_ctrl_regs (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .tick_i          (tick),
    .req_valid_i     (req_valid),
    .req_write_i     (req_write),
    .req_addr_i      (req_addr),
    .req_wdata_i     (req_wdata),
    .rsp_valid_o     (rsp_valid),
    .rsp_rdata_o     (rsp_rdata),
    .led_o           (led),
    .remap_o         (remap),
    .sys_reset_req_o (rst_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input int a);
    case (a)
      0:  return 32'h411A_3001;
      2:  return m_osc;
      3:  return {29'd0, m_remap, 1'b0, m_led};
      4:  return 32'h0010_0000;
      5:  return (m_lock == 16'hA05F) ? 32'h0001_A05F : {16'd0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      10: return m_cnt;
      12: return m_flags;
      14: return m_nv;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF;
    m_sdram = 32'h0001_1122; m_init = 32'h0000_0112;
    m_flags = '0; m_nv = '0; m_cnt = '0; m_lock = '0;
    m_led = 1'b0; m_remap = 1'b0;
  endtask

  // bus write plus model update from the requirements
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    case (a)
      2:  if (m_lock == 16'hA05F) m_osc = d;
      3:  begin m_led = d[0]; m_remap = d[2]; if (d[3]) m_flags = '0; end
      5:  m_lock = d[15:0];
      7:  if (m_lock == 16'hA05F) m_aux = d;
      8:  m_sdram = d;
      9:  m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      default: ;
    endcase
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk($sformatf("%s idx %0d", req, a), rsp_rdata, exp_rd(a));
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 64; a++) rd_chk(a, req);
  endtask

  task automatic ticks(input int k);
    @(negedge clk);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
    m_cnt = m_cnt + 32'(k);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R10 reset state over the whole map
    chk("R5 led reset", 32'(led), 32'd0);
    chk("R5 remap reset", 32'(remap), 32'd0);
    chk("R6 reset_req idle", 32'(rst_req), 32'd0);
    chk("R2 rsp_valid idle", 32'(rsp_valid), 32'd0);
    sweep("R1 reset sweep");
    @(negedge clk);
    chk("R2 rsp_valid drops", 32'(rsp_valid), 32'd0);

    // R4 locked writes ignored
    wr(2, 32'h1234_5678); wr(7, 32'hCAFE_F00D);
    rd_chk(2, "R4 osc locked"); rd_chk(7, "R4 aux locked");

    // R3 unlock key with upper bits set, R4 writes now land
    wr(5, 32'hFFFF_A05F);
    rd_chk(5, "R3 unlocked readback");
    wr(2, 32'h1234_5678); wr(7, 32'hCAFE_F00D);
    rd_chk(2, "R4 osc unlocked"); rd_chk(7, "R4 aux unlocked");
    wr(5, 32'h0001_A05E);
    rd_chk(5, "R3 near-key readback");
    wr(2, 32'h0BAD_0BAD);
    rd_chk(2, "R4 osc relocked");
    wr(5, 32'h0000_1234);
    rd_chk(5, "R3 plain readback");

    // R5 R6 control word
    wr(3, 32'hFFFF_FFFF);
    chk("R6 pulse after write", 32'(rst_req), 32'd1);
    chk("R5 led set", 32'(led), 32'd1);
    chk("R5 remap set", 32'(remap), 32'd1);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(rst_req), 32'd0);
    rd_chk(3, "R6 bit3 reads zero");
    for (int v = 0; v < 8; v++) begin
      wr(3, 32'(v));
      chk("R5 led", 32'(led), 32'(v & 1));
      chk("R5 remap", 32'(remap), 32'((v >> 2) & 1));
      chk("R6 no pulse", 32'(rst_req), 32'd0);
      rd_chk(3, "R5 ctrl readback");
    end

    // R7 R8 set/clear sweeps over walking and mixed patterns
    for (int b = 0; b < 32; b++) begin
      wr(12, 32'(1) << b); wr(14, 32'h8000_0000 >> b);
      rd_chk(12, "R7 flags set"); rd_chk(14, "R8 nv set");
    end
    rd_chk(13, "R7 clear index reads zero");
    rd_chk(15, "R8 clear index reads zero");
    for (int b = 0; b < 32; b += 3) begin
      wr(13, 32'h0F0F_0F0F << b); wr(15, 32'hF0F0_F0F0 >> b);
      rd_chk(12, "R7 flags clear"); rd_chk(14, "R8 nv clear");
    end
    wr(12, 32'hA5A5_5A5A); wr(14, 32'h1357_9BDF);
    wr(3, 32'h0000_0008);
    chk("R6 pulse on bit3", 32'(rst_req), 32'd1);
    rd_chk(12, "R8 flags wiped by reset request");
    rd_chk(14, "R8 nv kept over reset request");

    // R9 counter bursts
    rd_chk(10, "R9 counter idle");
    for (int k = 1; k < 40; k += 7) begin
      ticks(k);
      rd_chk(10, "R9 counter burst");
    end

    // R10 writable config words, then unmapped writes change nothing
    wr(8, 32'hDEAD_BEEF); wr(9, 32'h0000_0000);
    rd_chk(8, "R10 sdram"); rd_chk(9, "R10 init");
    for (int a = 0; a < 64; a++) begin
      if (!(a inside {2, 3, 5, 7, 8, 9, 12, 13, 14, 15})) wr(a, 32'hFFFF_FFFF);
    end
    chk("R10 led untouched", 32'(led), 32'(m_led));
    sweep("R10 after unmapped writes");

    done = 1'b1;
    summary();
  end
endmodule